// File: doc/BRIEF.md
# Countdown Watchdog Timer with APB Register Access

This peripheral watches over a system by counting down from a value that software loads. When the count hits zero, it requests a system restart. It sits on an APB3 bus as a slave. It has three registers: a count register, a mode register and an enable register. The countdown runs only while the mode register holds the arming key 0x5AB9 and the enable register holds the start code 0x3. Once running, the counter drops by one on every clock edge.

Software keeps the system alive by writing the count register again before the counter expires. That write reloads the counter on the spot. Writing zero to the enable register halts the count and keeps its current value. When the count expires, the block drives a restart request for exactly one clock and clears the enable register, so the restart request cannot fire again until software writes the start code again.

Every access completes in its access phase with no wait states and no error response.

Top module: `apb_wdog`

## Requirements
- R1: After a synchronous reset, the count, mode and enable registers all read 0 and `rst_req` is low.
- R2: The register offsets are 0x4 for count, 0x8 for mode and 0xC for enable. Mode and enable read back the last value written to them. Count reads back the live counter value.
- R3: A write to the count register (offset 0x4) loads the written value into the counter at that write's clock edge.
- R4: While mode equals 0x5AB9 and enable equals 0x3, the counter decreases by exactly one on every clock edge that carries no count write.
- R5: With any other mode value, or any other enable value, the counter holds its value.
- R6: Writing 0 to the enable register (offset 0xC) stops a running countdown. The counter keeps the value it had when it stopped.
- R7: In a running countdown loaded with N, `rst_req` goes high at the (N+1)-th clock edge after the edge that started the run. It stays high for exactly one cycle.
- R8: The edge that raises `rst_req` also clears the enable register to 0. No further pulse follows until the block is re-armed.
- R9: A count write during a running countdown restarts the timeout from the new value. A count write in the cycle where the counter would expire prevents the pulse.
- R10: Offsets that map to no register read as 0. Writes to them change none of the three registers.
- R11: `pready` is high at all times, so every transfer finishes in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, combinational from `paddr` |
| pready | output | 1 | Transfer complete, tied high |
| rst_req | output | 1 | One-cycle system restart request |

## Verification
The bench arms the countdown with small load values, including zero. It measures the clock distance from the starting write to the pulse, which shows whether the counter is off by one at the start or at the end. Random trials mix a correct or a wrong arming key with a correct or a wrong start code. These trials show that the count runs only when both match, and that a stopped counter keeps its loaded value. Repeated keep-alive writes confirm that a reload pushes the deadline back. Pairs of count reads taken a known number of cycles apart show a rate of exactly one step per cycle. Writes to unmapped offsets, and a zero written to enable mid-run, show that those accesses leave the state unchanged or frozen.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [31:0] OFF_COUNT  = 32'h4;
    localparam logic [31:0] OFF_MODE   = 32'h8;
    localparam logic [31:0] OFF_ENABLE = 32'hC;

    localparam logic [31:0] ARM_KEY    = 32'h0000_5AB9;
    localparam logic [31:0] START_CODE = 32'h0000_0003;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_MODE,
        SEL_ENABLE
    } wdog_sel_e;

    typedef struct packed {
        logic cnt_we;
        logic mode_we;
        logic en_we;
    } wdog_wr_t;

    function automatic wdog_sel_e decode_addr(input logic [31:0] a);
        wdog_sel_e s;
        case (a)
            OFF_COUNT:  s = SEL_COUNT;
            OFF_MODE:   s = SEL_MODE;
            OFF_ENABLE: s = SEL_ENABLE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdog_apb_if.sv
module wdog_apb_if
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [DATA_W-1:0] mode_val,
    input  logic [DATA_W-1:0] en_val,
    output wdog_wr_t          wr,
    output logic [DATA_W-1:0] prdata,
    output logic              pready
);

    localparam int PAD_W = DATA_W - CNT_W;

    wdog_sel_e         sel;
    logic              wr_xfer;
    logic [DATA_W-1:0] cnt_ext;

    assign sel     = decode_addr(32'(paddr));
    assign wr_xfer = psel && penable && pwrite;
    assign pready  = 1'b1;

    // Widen the counter to the bus width for readback.
    generate
        if (PAD_W > 0) begin : g_pad
            assign cnt_ext = {{PAD_W{1'b0}}, cnt_val};
        end else begin : g_nopad
            assign cnt_ext = cnt_val;
        end
    endgenerate

    always_comb begin
        wr.cnt_we  = wr_xfer && (sel == SEL_COUNT);
        wr.mode_we = wr_xfer && (sel == SEL_MODE);
        wr.en_we   = wr_xfer && (sel == SEL_ENABLE);
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  prdata = cnt_ext;
            SEL_MODE:   prdata = mode_val;
            SEL_ENABLE: prdata = en_val;
            default:    prdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wdog_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] en_q,
    output logic              run
);

    localparam logic [DATA_W-1:0] KEY   = DATA_W'(ARM_KEY);
    localparam logic [DATA_W-1:0] START = DATA_W'(START_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr.mode_we) begin
            mode_q <= wdata;
        end
    end

    // Expiry takes priority over a software enable write.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (expire) begin
            en_q <= '0;
        end else if (wr.en_we) begin
            en_q <= wdata;
        end
    end

    assign run = (en_q == START) && (mode_q == KEY);

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              expire,
    output logic              rst_req
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);
    // A reload in the same cycle rescues the system.
    assign expire  = run && at_zero && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (run && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire;
        end
    end

endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              rst_req
);

    wdog_wr_t          wr;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] en_q;
    logic              run;
    logic              expire;

    wdog_apb_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_if (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .cnt_val  (cnt_q),
        .mode_val (mode_q),
        .en_val   (en_q),
        .wr       (wr),
        .prdata   (prdata),
        .pready   (pready)
    );

    wdog_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .wdata  (pwdata),
        .expire (expire),
        .mode_q (mode_q),
        .en_q   (en_q),
        .run    (run)
    );

    wdog_cnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (wr.cnt_we),
        .wdata   (pwdata),
        .run     (run),
        .cnt_q   (cnt_q),
        .expire  (expire),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] en_val,
    input logic              run
);

    logic cnt_we;
    assign cnt_we = psel && penable && pwrite && (32'(paddr) == 32'h4);

    // R11
    pready_high_chk: assert property (@(posedge clk) disable iff (rst) pready);

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> cnt == $past(pwdata[CNT_W-1:0]));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0 && !cnt_we) |=> cnt == $past(cnt) - 1'b1);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(cnt));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8
    disarm_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> en_val == '0);

    // R9
    kick_blocks_fire_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> !rst_req);

endmodule

bind apb_wdog wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pready  (pready),
    .rst_req (rst_req),
    .cnt     (cnt_q),
    .en_val  (en_q),
    .run     (run)
);

// File: tb/sim_apb_wdog.sv
module sim_apb_wdog;

    localparam int CLK_T  = 10;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CNT  = 12'h004;
    localparam logic [ADDR_W-1:0] A_MODE = 12'h008;
    localparam logic [ADDR_W-1:0] A_EN   = 12'h00C;
    localparam logic [31:0] KEY   = 32'h5AB9;
    localparam logic [31:0] START = 32'h3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic              pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready;
    logic              rst_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #(CLK_T/2) clk = ~clk;

    apb_wdog u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .rst_req(rst_req)
    );

    always @(negedge clk) if (!rst && rst_req) pulses++;

    function automatic bit will_run(input logic [31:0] m, input logic [31:0] e);
        return (m == KEY) && (e == START);
    endfunction

    function automatic int fire_delay(input int n);
        return n + 1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        checks++;
        if (pready !== 1'b1) begin
            fails++;
            $display("FAIL R11 actual=%0b expected=1", pready);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Call right after the starting write returns; counts edges until the pulse.
    task automatic wait_fire(input int lim, output int c);
        c = 0;
        while (rst_req !== 1'b1 && c < lim) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(CLK_T * 150000);
        checks++; fails++;
        $display("FAIL watchdog run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int c, p0;
        void'($urandom(32'h1D5));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rst_req", {31'b0, rst_req}, 0);
        apb_rd(A_CNT, v);  check("R1 count", v, 0);
        apb_rd(A_MODE, v); check("R1 mode", v, 0);
        apb_rd(A_EN, v);   check("R1 enable", v, 0);

        // R2 R3 readback while stopped
        apb_wr(A_CNT, 32'hDEAD_0123);
        apb_rd(A_CNT, v);  check("R3 count load", v, 32'hDEAD_0123);
        apb_wr(A_MODE, 32'h1234);
        apb_rd(A_MODE, v); check("R2 mode readback", v, 32'h1234);
        apb_wr(A_EN, 32'h7);
        apb_rd(A_EN, v);   check("R2 enable readback", v, 32'h7);
        apb_rd(A_CNT, v);  check("R5 stopped count", v, 32'hDEAD_0123);

        // R10 unmapped offsets
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_wr(12'h010, 32'h5555_5555);
        apb_wr(12'h005, 32'h0);
        apb_rd(12'h000, v); check("R10 unmapped read 0x0", v, 0);
        apb_rd(12'h010, v); check("R10 unmapped read 0x10", v, 0);
        apb_rd(A_CNT, v);  check("R10 count untouched", v, 32'hDEAD_0123);
        apb_rd(A_MODE, v); check("R10 mode untouched", v, 32'h1234);
        apb_rd(A_EN, v);   check("R10 enable untouched", v, 32'h7);

        // R4 rate and R6 stop
        apb_wr(A_EN, 0);
        apb_wr(A_CNT, 32'd1000);
        apb_wr(A_MODE, KEY);
        apb_wr(A_EN, START);
        apb_rd(A_CNT, v);
        repeat (5) @(negedge clk);
        apb_rd(A_CNT, v2);
        check("R4 decrement rate", v - v2, 32'd7);
        apb_wr(A_EN, 0);
        apb_rd(A_CNT, v);
        repeat (6) @(negedge clk);
        apb_rd(A_CNT, v2);
        check("R6 frozen after stop", v2, v);
        check("R6 stopped below load", {31'b0, (v < 32'd1000)}, 1);

        // R7 R8 directed: load 0 and load 5
        for (int k = 0; k < 2; k++) begin
            int n = (k == 0) ? 0 : 5;
            apb_wr(A_CNT, n);
            apb_wr(A_EN, START);
            p0 = pulses;
            wait_fire(200, c);
            check("R7 fire delay", c, fire_delay(n));
            @(negedge clk);
            check("R7 pulse width", {31'b0, rst_req}, 0);
            apb_rd(A_EN, v);   check("R8 enable cleared", v, 0);
            apb_rd(A_MODE, v); check("R8 mode kept", v, KEY);
            repeat (10) @(negedge clk);
            check("R8 single pulse", pulses - p0, 1);
        end

        // R9 keep-alive
        apb_wr(A_CNT, 20);
        apb_wr(A_EN, START);
        p0 = pulses;
        for (int k = 0; k < 6; k++) begin
            repeat (12) @(negedge clk);
            apb_wr(A_CNT, 20);
        end
        check("R9 no pulse while kicked", pulses - p0, 0);
        wait_fire(200, c);
        check("R9 delay from last kick", c, fire_delay(20));

        // R4 R5 random arming patterns
        for (int it = 0; it < 16; it++) begin
            int n = int'($urandom_range(40, 0));
            logic [31:0] m = ($urandom_range(1, 0) == 1) ? KEY : ($urandom() | 32'h1_0000);
            logic [31:0] e = ($urandom_range(1, 0) == 1) ? START : {$urandom_range(255, 4)};
            apb_wr(A_EN, 0);
            apb_wr(A_CNT, n);
            apb_wr(A_MODE, m);
            apb_wr(A_EN, e);
            p0 = pulses;
            if (will_run(m, e)) begin
                wait_fire(200, c);
                check("R4 random fire delay", c, fire_delay(n));
                @(negedge clk);
            end else begin
                repeat (n + 10) @(negedge clk);
                check("R5 no pulse when not armed", pulses - p0, 0);
                apb_rd(A_CNT, v);
                check("R5 count held", v, n);
            end
        end

        summary();
        $finish;
    end

endmodule